// File: doc/BRIEF.md
# Multicast Destination Filter Receiver

This block sits beside a router that listens on a shared broadcast channel. Each multicast message on that channel starts with a header flit. The header carries a destination vector with one bit per core and the number of payload flits that follow. The receiver serves a small fixed set of local cores, two by default. Their vector indices come from configuration inputs. On a header it looks only at the vector bits of its own cores. If any of them is set, it takes the following payload flits and copies each one, one cycle after it arrives, to every addressed local core. There is no store-and-forward stage.

If none of its cores is addressed, the receiver raises a power-gate enable for exactly as many cycles as the header announces. It ignores the channel for that time and then expects a new header. A header that announces zero payload flits closes the message at once.

Payload flits are expected back-to-back after a header that the receiver sleeps through. While receiving, idle cycles on the channel are allowed and are not counted.

Top module: `mc_dest_filter_rx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pwr_gate` is 0 and every bit of `core_valid` is 0. Channel activity during reset has no effect, and the first valid flit after reset is decoded as a header.
- R2: The header layout is as follows. Bits [DEST_BITS-1:0] of `ch_flit` form the destination vector, where bit k addresses core index k. Bits [DEST_BITS+CNT_W-1:DEST_BITS] hold the payload flit count, as an unsigned number. The header flit itself is never forwarded to a core.
- R3: Only the vector bits at the configured served indices are examined. Setting any other bit has no effect on whether the message is taken.
- R4: When a header addresses at least one served core and its count N is greater than 0, the next N valid flits are taken. Each taken flit appears unchanged on the slice of `core_flit` for each addressed served core, with that core's `core_valid` bit high, in the cycle after it was on the channel.
- R5: Served core slot s uses the index `cfg_core_idx[s*IDX_W +: IDX_W]`. A message reaches zero, one or both slots, depending on which of their vector bits are set, and both slots may be reached by the same flit.
- R6: When a header with count N > 0 addresses no served core, `pwr_gate` is 1 for exactly N cycles, starting in the cycle after the header. No `core_valid` bit rises during that time or because of flits sent during it, even flits that look like headers addressing a served core.
- R7: The first valid flit on the channel after the gated period ends is decoded as a new header.
- R8: A header whose count is 0 completes at once. It causes no gating and no delivery, and the next valid flit is a header.
- R9: The served indices are used only when a header is decoded. Changing `cfg_core_idx` during a message does not change which slots receive that message's payload.
- R10: After the Nth taken flit, nothing more is forwarded. The next valid flit is decoded as a header.
- R11: Cycles with `ch_valid` low while a message is being taken are neither forwarded nor counted toward N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_valid | input | 1 | A flit is present on the broadcast channel this cycle |
| ch_flit | input | FLIT_W (72) | Channel flit (header or payload) |
| cfg_core_idx | input | SERVED*IDX_W (12) | Vector index of each served core, slot 0 in the low bits |
| core_valid | output | SERVED (2) | Per-slot flit delivery strobe |
| core_flit | output | SERVED*FLIT_W (144) | Per-slot delivered flit, slot 0 in the low bits |
| pwr_gate | output | 1 | Power-gate enable while sleeping through a message not addressed here |

## Verification
The bench builds the block with its default parameters: a 64-bit destination vector, an 8-bit count and two served slots. With these settings it can set every vector bit and drive the largest count of 255 in a directed sleep case. Random messages with counts up to 12 mix taken, partly taken and slept-through traffic, with idle gaps while receiving. Directed cases cover a zero count, a count of one, both slots on the same index, a vector with every bit set except the served ones, and a configuration change in the middle of a message.

// File: rtl/mcrx_pkg.sv
// Package: shared types for the multicast destination filter receiver.
// Assumes nothing beyond being compiled before the modules that import it.
package mcrx_pkg;

    // Receiver phase: waiting for a header, taking payload, or sleeping.
    typedef enum logic [1:0] {
        RX_HDR   = 2'd0,
        RX_TAKE  = 2'd1,
        RX_SLEEP = 2'd2
    } rx_state_e;

endpackage

// File: rtl/mcrx_hdr_decode.sv
// Module: mcrx_hdr_decode
// Splits a channel flit into its header fields. It picks the destination-vector
// bit of each served slot and extracts the payload count.
// Assumes DEST_BITS is a power of two, so that a slot index covers the vector exactly.
module mcrx_hdr_decode #(
    parameter int FLIT_W    = 72,
    parameter int DEST_BITS = 64,
    parameter int CNT_W     = 8,
    parameter int SERVED    = 2,
    parameter int IDX_W     = $clog2(DEST_BITS)
) (
    input  logic [FLIT_W-1:0]       flit,
    input  logic [SERVED*IDX_W-1:0] idx_bus,
    output logic [SERVED-1:0]       hit_mask,
    output logic [CNT_W-1:0]        hdr_count
);

    logic [DEST_BITS-1:0] dest_vec;

    // Field extraction from the fixed header layout.
    assign dest_vec  = flit[DEST_BITS-1:0];
    assign hdr_count = flit[DEST_BITS +: CNT_W];

    // One vector-bit pick per served slot.
    for (genvar s = 0; s < SERVED; s++) begin : g_pick
        assign hit_mask[s] = dest_vec[idx_bus[s*IDX_W +: IDX_W]];
    end

    // The upper flit bits are payload only and are not used here.
    if (FLIT_W > DEST_BITS + CNT_W) begin : g_spare
        logic spare_unused;
        assign spare_unused = ^flit[FLIT_W-1:DEST_BITS+CNT_W];
    end

endmodule

// File: rtl/mcrx_seq.sv
// Module: mcrx_seq
// Message sequencer. It decodes headers, latches the per-slot delivery mask,
// and counts down either the taken flits (in TAKE) or the clock cycles (in SLEEP).
// Assumes the payload of a slept-through message arrives back-to-back.
module mcrx_seq
    import mcrx_pkg::*;
#(
    parameter int SERVED = 2,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_valid,
    input  logic [SERVED-1:0] hit_mask,
    input  logic [CNT_W-1:0]  hdr_count,
    output logic [SERVED-1:0] take_mask,
    output logic              gate
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    rx_state_e         state_q;
    logic [CNT_W-1:0]  remain_q;
    logic [SERVED-1:0] mask_q;

    // Phase, remaining-length counter and delivery mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_HDR;
            remain_q <= CNT_ZERO;
            mask_q   <= '0;
        end else begin
            unique case (state_q)
                RX_HDR: begin
                    if (ch_valid && (hdr_count != CNT_ZERO)) begin
                        remain_q <= hdr_count;
                        if (|hit_mask) begin
                            state_q <= RX_TAKE;
                            mask_q  <= hit_mask;
                        end else begin
                            state_q <= RX_SLEEP;
                        end
                    end
                end
                RX_TAKE: begin
                    if (ch_valid) begin
                        remain_q <= remain_q - CNT_ONE;
                        if (remain_q == CNT_ONE) begin
                            state_q <= RX_HDR;
                            mask_q  <= '0;
                        end
                    end
                end
                RX_SLEEP: begin
                    remain_q <= remain_q - CNT_ONE;
                    if (remain_q == CNT_ONE) begin
                        state_q <= RX_HDR;
                    end
                end
                default: begin
                    state_q <= RX_HDR;
                    mask_q  <= '0;
                end
            endcase
        end
    end

    // The mask is cleared outside TAKE, so it also marks the payload phase.
    assign take_mask = mask_q;
    assign gate      = (state_q == RX_SLEEP);

endmodule

// File: rtl/mcrx_fanout.sv
// Module: mcrx_fanout
// Per-slot output registers. A channel flit is copied to each slot whose bit is
// set in the delivery mask, one cycle after it arrives.
// Assumes take_mask is all zero whenever no message is being taken.
module mcrx_fanout #(
    parameter int FLIT_W = 72,
    parameter int SERVED = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ch_valid,
    input  logic [FLIT_W-1:0]        ch_flit,
    input  logic [SERVED-1:0]        take_mask,
    output logic [SERVED-1:0]        core_valid,
    output logic [SERVED*FLIT_W-1:0] core_flit
);

    for (genvar s = 0; s < SERVED; s++) begin : g_slot
        logic              fwd;
        logic              vld_q;
        logic [FLIT_W-1:0] dat_q;

        assign fwd = ch_valid & take_mask[s];

        // Strobe register for this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= fwd;
        end

        // The data register loads only on delivery, to cut toggling.
        always_ff @(posedge clk) begin
            if (!rst_n)   dat_q <= '0;
            else if (fwd) dat_q <= ch_flit;
        end

        assign core_valid[s]                = vld_q;
        assign core_flit[s*FLIT_W +: FLIT_W] = dat_q;
    end

endmodule

// File: rtl/mc_dest_filter_rx.sv
// Module: mc_dest_filter_rx (top)
// Multicast receiver with destination filtering and power gating. The header is
// decoded against the served slot indices. Addressed payload is fanned out
// flit by flit. A message addressed to no served core is slept through for its
// announced length.
// Assumes FLIT_W >= DEST_BITS + CNT_W and DEST_BITS a power of two.
module mc_dest_filter_rx #(
    parameter int DEST_BITS = 64,
    parameter int CNT_W     = 8,
    parameter int FLIT_W    = 72,
    parameter int SERVED    = 2,
    parameter int IDX_W     = $clog2(DEST_BITS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ch_valid,
    input  logic [FLIT_W-1:0]        ch_flit,
    input  logic [SERVED*IDX_W-1:0]  cfg_core_idx,
    output logic [SERVED-1:0]        core_valid,
    output logic [SERVED*FLIT_W-1:0] core_flit,
    output logic                     pwr_gate
);

    logic [SERVED-1:0] hit_mask;
    logic [CNT_W-1:0]  hdr_count;
    logic [SERVED-1:0] take_mask;

    // Header field decode against the live slot indices.
    mcrx_hdr_decode #(
        .FLIT_W(FLIT_W), .DEST_BITS(DEST_BITS), .CNT_W(CNT_W),
        .SERVED(SERVED), .IDX_W(IDX_W)
    ) u_dec (
        .flit(ch_flit), .idx_bus(cfg_core_idx),
        .hit_mask(hit_mask), .hdr_count(hdr_count)
    );

    // Message phase and length tracking.
    mcrx_seq #(.SERVED(SERVED), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid),
        .hit_mask(hit_mask), .hdr_count(hdr_count),
        .take_mask(take_mask), .gate(pwr_gate)
    );

    // Per-slot delivery registers.
    mcrx_fanout #(.FLIT_W(FLIT_W), .SERVED(SERVED)) u_fan (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_flit(ch_flit),
        .take_mask(take_mask), .core_valid(core_valid), .core_flit(core_flit)
    );

endmodule

// File: rtl/mc_dest_filter_rx_chk.sv
// Module: mc_dest_filter_rx_chk
// Port-level temporal checks for mc_dest_filter_rx, attached by bind.
// Assumes the same parameters as the top it is bound to.
module mc_dest_filter_rx_chk #(
    parameter int DEST_BITS = 64,
    parameter int CNT_W     = 8,
    parameter int FLIT_W    = 72,
    parameter int SERVED    = 2,
    parameter int IDX_W     = $clog2(DEST_BITS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ch_valid,
    input logic [FLIT_W-1:0]        ch_flit,
    input logic [SERVED*IDX_W-1:0]  cfg_core_idx,
    input logic [SERVED-1:0]        core_valid,
    input logic [SERVED*FLIT_W-1:0] core_flit,
    input logic                     pwr_gate
);

    logic [DEST_BITS-1:0] dvec;
    logic [SERVED-1:0]    served_hit;

    assign dvec = ch_flit[DEST_BITS-1:0];
    for (genvar s = 0; s < SERVED; s++) begin : g_hit
        assign served_hit[s] = dvec[cfg_core_idx[s*IDX_W +: IDX_W]];
    end

    AST_GATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_gate |-> (core_valid == '0)); // R6

    AST_SLEEP_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_gate) |-> ($past(ch_valid) && !$past(|served_hit))); // R6

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_gate) |-> (core_valid == '0)); // R7

    AST_DELIVERY_NEEDS_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_valid) |-> $past(ch_valid)); // R11

    for (genvar s = 0; s < SERVED; s++) begin : g_data
        AST_FLIT_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
            core_valid[s] |-> (core_flit[s*FLIT_W +: FLIT_W] == $past(ch_flit))); // R4
    end

endmodule

bind mc_dest_filter_rx mc_dest_filter_rx_chk #(
    .DEST_BITS(DEST_BITS), .CNT_W(CNT_W), .FLIT_W(FLIT_W),
    .SERVED(SERVED), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/mc_dest_filter_rx_test.sv
`timescale 1ns/1ps
// Bench: mc_dest_filter_rx_test
// Mixed directed and seeded-random multicast messages, each checked cycle by
// cycle against expectations computed from the requirements.
module mc_dest_filter_rx_test;

    localparam int DB = 64;
    localparam int CW = 8;
    localparam int FW = 72;
    localparam int SV = 2;
    localparam int IW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ch_valid = 1'b0;
    logic [FW-1:0]  ch_flit = '0;
    logic [SV*IW-1:0] cfg_core_idx = '0;
    logic [SV-1:0]  core_valid;
    logic [SV*FW-1:0] core_flit;
    logic           pwr_gate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [IW-1:0] c0, c1;

    always #2.5 clk = ~clk;

    mc_dest_filter_rx uut (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_flit(ch_flit),
        .cfg_core_idx(cfg_core_idx), .core_valid(core_valid),
        .core_flit(core_flit), .pwr_gate(pwr_gate)
    );

    // Expected delivery mask: the vector bits at each slot's index.
    function automatic logic [1:0] exp_mask(input logic [63:0] dbv,
                                            input logic [5:0] i0, input logic [5:0] i1);
        return {dbv[i1], dbv[i0]};
    endfunction

    function automatic logic [FW-1:0] rnd_flit();
        return {$urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [5:0] i0, input logic [5:0] i1);
        c0 = i0;
        c1 = i1;
        cfg_core_idx = {i1, i0};
    endtask

    // Sends one message starting at a negedge and returns at a negedge.
    task automatic run_msg(input logic [63:0] dbv, input int cnt, input int gap_pct,
                           input bit cfg_flip);
        logic [1:0]    m;
        logic [FW-1:0] f;
        logic          v;
        int            sent;
        m = exp_mask(dbv, c0, c1);
        ch_valid = 1'b1;
        ch_flit  = {CW'(cnt), dbv};
        @(negedge clk);
        ch_valid = 1'b0;
        chk("R2 header flit not forwarded", FW'(core_valid), '0);
        if (cnt == 0) begin
            chk("R8 zero count causes no gating", FW'(pwr_gate), '0);
            return;
        end
        if (m == 2'b00) begin
            for (int i = 1; i <= cnt; i++) begin
                chk("R6 gate high during sleep", FW'(pwr_gate), 1);
                chk("R6 no delivery during sleep", FW'(core_valid), '0);
                ch_valid = 1'b1;
                ch_flit  = {CW'(3), {DB{1'b1}}};
                @(negedge clk);
            end
            ch_valid = 1'b0;
            chk("R6 gate low after exactly N cycles", FW'(pwr_gate), '0);
            chk("R6 flits sent while gated ignored", FW'(core_valid), '0);
            return;
        end
        sent = 0;
        while (sent < cnt) begin
            if (cfg_flip && sent == 1) set_cfg(6'($urandom), 6'($urandom));
            v = (int'($urandom % 100) >= gap_pct);
            f = rnd_flit();
            ch_valid = v;
            ch_flit  = f;
            if (v) sent++;
            @(negedge clk);
            chk("R11 R4 R9 delivery strobes", FW'(core_valid), v ? FW'(m) : '0);
            chk("R4 gate stays low while taking", FW'(pwr_gate), '0);
            for (int s = 0; s < SV; s++)
                if (v && m[s]) chk("R5 delivered flit data", core_flit[s*FW +: FW], f);
        end
        ch_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_2468));
        set_cfg(6'd5, 6'd40);
        // R1: channel activity while reset is held
        repeat (2) @(negedge clk);
        ch_valid = 1'b1;
        ch_flit  = {CW'(4), {DB{1'b0}}};
        repeat (3) @(negedge clk);
        chk("R1 gate low in reset", FW'(pwr_gate), '0);
        chk("R1 strobes low in reset", FW'(core_valid), '0);
        ch_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gate low after reset", FW'(pwr_gate), '0);
        chk("R1 strobes low after reset", FW'(core_valid), '0);

        // R1 R5: first flit after reset is a header for slot 0 only
        run_msg(64'h1 << 5, 3, 0, 1'b0);
        // R5: slot 1 only, then both slots (R10 follows each)
        run_msg(64'h1 << 40, 2, 30, 1'b0);
        run_msg((64'h1 << 40) | (64'h1 << 5), 4, 20, 1'b0);
        // R3: every bit except the served ones leads to sleep
        run_msg(~((64'h1 << 40) | (64'h1 << 5)), 5, 0, 1'b0);
        // R7: a header right after wake-up is taken
        run_msg(64'h1 << 40, 1, 0, 1'b0);
        // R8: zero count, then an immediate header
        run_msg(64'h1 << 5, 0, 0, 1'b0);
        run_msg(64'h0, 0, 0, 1'b0);
        run_msg(64'h1 << 5, 2, 0, 1'b0);
        // R6: longest sleep, count 255
        run_msg(64'h0, 255, 0, 1'b0);
        // R5: both slots on one index
        set_cfg(6'd63, 6'd63);
        run_msg(64'h1 << 63, 3, 10, 1'b0);
        // R9: configuration changes in the middle of a message
        set_cfg(6'd9, 6'd17);
        run_msg(64'h1 << 9, 6, 25, 1'b1);
        set_cfg(6'd9, 6'd17);
        run_msg(64'h1 << 17, 6, 25, 1'b1);

        // Random traffic over all R-requirements
        for (int k = 0; k < 300; k++) begin
            logic [63:0] d;
            if ($urandom % 8 == 0) set_cfg(6'($urandom), 6'($urandom));
            d = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom % 3 == 0) d[c0] = 1'b1;
            run_msg(d, int'($urandom % 13), int'($urandom % 40), ($urandom % 5 == 0));
        end

        @(negedge clk);
        chk("R10 quiet after final message", FW'(core_valid), '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule